// File: doc/BRIEF.md
# Delayed/Split Read Tracker

This block keeps the pending inbound read requests of a bus bridge. The requests arrive from a secondary PCI or PCI-X bus and are forwarded to an upstream port. Each request takes a slot in a small table. The block sends a bounded number of slots upstream at once, stores the completion beats and status that come back, and hands the data to the original requester. Completions for different slots may return in any order. For each request it decides how the secondary side ends: normal data, a target abort, or a split completion error message. When an abort is seen or signalled, it pulses the matching status-set strobe.

A request is a single-cycle strobe. The block answers it one cycle later with a two-bit response code. Upstream launches use a valid/ready pair. Completion beats arrive as strobes tagged with the slot index. Delivery toward the requester uses a valid/ready pair. In PCI mode a slot is delivered only after the master repeats the same command and address, which models a retry followed by a reconnect. In PCI-X mode a slot is delivered as soon as its data is present, which models split completions.

Top module: `rd_defer_tracker`

## Requirements
- R1: A new request takes the lowest free slot. The response arrives one cycle after the request strobe, with code 2 (split response) in PCI-X mode and code 1 (retried, queued) in PCI mode. ENTRIES slots can be pending at once.
- R2: At most MAX_UP slots are outstanding upstream at any time. Waiting slots launch lowest index first, and `up_idx` names the slot being launched.
- R3: A PCI-mode slot fetches PF_BYTES upstream (`up_len`) for every command when prefetch is not suppressed.
- R4: When `pf_off_mrd` is 1, a PCI memory-read request (command 4'b0110) fetches exactly its byte count. Other PCI commands still fetch PF_BYTES.
- R5: A PCI-X slot fetches exactly its request byte count, whatever the command or `pf_off_mrd`.
- R6: When every slot is in use, a new request gets code 0 (retry) and no slot is taken.
- R7: In PCI mode, a request whose command and address equal those of a pending PCI slot is a repeat, not a new request. It answers code 3 (connect) when that slot holds data or a final error status, and code 0 otherwise. A PCI slot delivers nothing until it is connected this way.
- R8: Data beats leave in arrival order within a slot, with that slot's requester ID and tag, and kind 0 (data). `dlv_last` marks the final beat of a completed slot, and the slot is then freed. A PCI slot that runs out of buffered data before completing stops delivering until it is connected again.
- R9: On an upstream abort, a PCI slot gives kind 1 (target abort) when no beat of it has been delivered yet, or when it is connected again after its buffered data ran out. Good data already buffered while a stream is in progress is still delivered first.
- R10: On an upstream abort, a PCI-X slot drops any buffered data and at once delivers a split completion error of kind 2 (master abort, completion status 1) or kind 3 (target abort, completion status 2), with `dlv_last` set.
- R11: Upstream completion status 1 pulses `st_rcv_ma` and status 2 pulses `st_rcv_ta`, in the cycle after the completion is taken. Delivering kind 1 or kind 3 pulses `st_sig_ta` in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcix_mode | input | 1 | Secondary bus mode for the request: 1 PCI-X, 0 PCI |
| pf_off_mrd | input | 1 | Suppress prefetch for PCI memory-read |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 4 | Bus command |
| req_addr | input | AW | Start address |
| req_bcnt | input | BCW | Requested byte count |
| req_rid | input | IDW | Requester ID |
| req_tag | input | TAGW | Requester tag |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_code | output | 2 | 0 retry, 1 queued retry, 2 split response, 3 connect |
| up_valid | output | 1 | Upstream launch valid |
| up_ready | input | 1 | Upstream launch ready |
| up_idx | output | log2(ENTRIES) | Slot index of the launch |
| up_cmd | output | 4 | Command of the launch |
| up_addr | output | AW | Address of the launch |
| up_len | output | BCW | Bytes to fetch |
| cpl_valid | input | 1 | Upstream completion beat strobe |
| cpl_idx | input | log2(ENTRIES) | Slot the beat belongs to |
| cpl_data | input | DW | Beat data |
| cpl_last | input | 1 | Final beat of the slot |
| cpl_st | input | 2 | 0 good, 1 master abort, 2 target abort |
| dlv_valid | output | 1 | Delivery valid |
| dlv_ready | input | 1 | Delivery ready |
| dlv_kind | output | 2 | 0 data, 1 target abort, 2 split error master abort, 3 split error target abort |
| dlv_data | output | DW | Delivered data |
| dlv_rid | output | IDW | Requester ID of the delivery |
| dlv_tag | output | TAGW | Tag of the delivery |
| dlv_last | output | 1 | Final delivery of the slot |
| st_rcv_ma | output | 1 | Set strobe: received master abort |
| st_rcv_ta | output | 1 | Set strobe: received target abort |
| st_sig_ta | output | 1 | Set strobe: signalled target abort |

## Verification
The bench uses the default parameters: eight slots, four upstream launches, four beats per slot and a 16-byte prefetch. With these values a short run can fill the table completely, which triggers the retry on a full table. It can also hold the upstream cap with four slots still waiting. Random byte counts from 4 to 16 reach single-beat and full-buffer slots, and completing slots in random order exercises both launch refill and ordering within a slot. Directed runs cover the three abort timings on each bus mode.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_OUT  = 2'd2,
        SLOT_DONE = 2'd3
    } slot_st_e;

    localparam logic [3:0] CMD_MRD     = 4'b0110;

    localparam logic [1:0] RSP_RETRY   = 2'd0;
    localparam logic [1:0] RSP_QUEUED  = 2'd1;
    localparam logic [1:0] RSP_SPLIT   = 2'd2;
    localparam logic [1:0] RSP_CONNECT = 2'd3;

    localparam logic [1:0] CST_OK      = 2'd0;
    localparam logic [1:0] CST_MA      = 2'd1;
    localparam logic [1:0] CST_TA      = 2'd2;

    localparam logic [1:0] DK_DATA     = 2'd0;
    localparam logic [1:0] DK_TABORT   = 2'd1;
    localparam logic [1:0] DK_SCE_MA   = 2'd2;
    localparam logic [1:0] DK_SCE_TA   = 2'd3;
endpackage

// File: rtl/rdt_first_set.sv
module rdt_first_set #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rdt_fetch_len.sv
module rdt_fetch_len
    import rdt_pkg::*;
#(
    parameter int BCW      = 5,
    parameter int PF_BYTES = 16
) (
    input  logic           pcix,
    input  logic           pf_off,
    input  logic [3:0]     cmd,
    input  logic [BCW-1:0] bcnt,
    output logic [BCW-1:0] len
);
    always_comb begin
        if (pcix || (pf_off && cmd == CMD_MRD)) len = bcnt;
        else                                    len = BCW'(PF_BYTES);
    end
endmodule

// File: rtl/rd_defer_tracker.sv
module rd_defer_tracker
    import rdt_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int MAX_UP   = 4,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int BCW      = 5,
    parameter int IDW      = 16,
    parameter int TAGW     = 5,
    parameter int BEATS    = 4,
    parameter int PF_BYTES = 16,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pcix_mode,
    input  logic            pf_off_mrd,
    input  logic            req_valid,
    input  logic [3:0]      req_cmd,
    input  logic [AW-1:0]   req_addr,
    input  logic [BCW-1:0]  req_bcnt,
    input  logic [IDW-1:0]  req_rid,
    input  logic [TAGW-1:0] req_tag,
    output logic            rsp_valid,
    output logic [1:0]      rsp_code,
    output logic            up_valid,
    input  logic            up_ready,
    output logic [IW-1:0]   up_idx,
    output logic [3:0]      up_cmd,
    output logic [AW-1:0]   up_addr,
    output logic [BCW-1:0]  up_len,
    input  logic            cpl_valid,
    input  logic [IW-1:0]   cpl_idx,
    input  logic [DW-1:0]   cpl_data,
    input  logic            cpl_last,
    input  logic [1:0]      cpl_st,
    output logic            dlv_valid,
    input  logic            dlv_ready,
    output logic [1:0]      dlv_kind,
    output logic [DW-1:0]   dlv_data,
    output logic [IDW-1:0]  dlv_rid,
    output logic [TAGW-1:0] dlv_tag,
    output logic            dlv_last,
    output logic            st_rcv_ma,
    output logic            st_rcv_ta,
    output logic            st_sig_ta
);
    localparam int BI = $clog2(BEATS);
    localparam int PW = BI + 1;
    localparam int CW = $clog2(ENTRIES + 1);

    typedef struct packed {
        slot_st_e                 st;
        logic                     pcix;
        logic                     go;
        logic                     started;
        logic [1:0]               err;
        logic [3:0]               cmd;
        logic [AW-1:0]            addr;
        logic [BCW-1:0]           len;
        logic [IDW-1:0]           rid;
        logic [TAGW-1:0]          tag;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [BEATS-1:0][DW-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic                rsp_v;
        logic [1:0]          rsp_c;
        logic                rma;
        logic                rta;
        logic                sta;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0] free_v, wait_v, out_v, has_v, match_v, dlv_v;
    logic               free_hit, wait_hit, dlv_hit, match_hit;
    logic [IW-1:0]      free_idx, launch_idx, dlv_idx, match_idx;
    logic [CW-1:0]      n_out;
    logic [BCW-1:0]     fetch_len;
    slot_t              dv;
    logic               dv_empty, dv_tail;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign free_v[g]  = s_q.slot[g].st == SLOT_FREE;
        assign wait_v[g]  = s_q.slot[g].st == SLOT_WAIT;
        assign out_v[g]   = s_q.slot[g].st == SLOT_OUT;
        assign has_v[g]   = (s_q.slot[g].st == SLOT_OUT || s_q.slot[g].st == SLOT_DONE)
                          && (s_q.slot[g].err != CST_OK || s_q.slot[g].rp != s_q.slot[g].wp);
        assign match_v[g] = !pcix_mode && !free_v[g] && !s_q.slot[g].pcix
                          && s_q.slot[g].cmd == req_cmd && s_q.slot[g].addr == req_addr;
        assign dlv_v[g]   = has_v[g] && (s_q.slot[g].pcix || s_q.slot[g].go);
    end

    always_comb begin
        n_out = '0;
        for (int i = 0; i < ENTRIES; i++) n_out = n_out + CW'(out_v[i]);
    end

    rdt_first_set #(.N(ENTRIES), .IW(IW)) u_pick_free  (.vec(free_v),  .hit(free_hit),  .idx(free_idx));
    rdt_first_set #(.N(ENTRIES), .IW(IW)) u_pick_wait  (.vec(wait_v),  .hit(wait_hit),  .idx(launch_idx));
    rdt_first_set #(.N(ENTRIES), .IW(IW)) u_pick_dlv   (.vec(dlv_v),   .hit(dlv_hit),   .idx(dlv_idx));
    rdt_first_set #(.N(ENTRIES), .IW(IW)) u_pick_match (.vec(match_v), .hit(match_hit), .idx(match_idx));

    rdt_fetch_len #(.BCW(BCW), .PF_BYTES(PF_BYTES)) u_len (
        .pcix(pcix_mode), .pf_off(pf_off_mrd), .cmd(req_cmd), .bcnt(req_bcnt), .len(fetch_len)
    );

    // Upstream launch view
    assign up_valid = wait_hit && (n_out < CW'(MAX_UP));
    assign up_idx   = launch_idx;
    assign up_cmd   = s_q.slot[launch_idx].cmd;
    assign up_addr  = s_q.slot[launch_idx].addr;
    assign up_len   = s_q.slot[launch_idx].len;

    // Delivery view
    assign dv       = s_q.slot[dlv_idx];
    assign dv_empty = dv.rp == dv.wp;
    assign dv_tail  = PW'(dv.rp + PW'(1)) == dv.wp;

    always_comb begin
        dlv_valid = dlv_hit;
        dlv_rid   = dv.rid;
        dlv_tag   = dv.tag;
        dlv_data  = dv.data[dv.rp[BI-1:0]];
        if (dv.pcix) begin
            if (dv.err != CST_OK) begin
                dlv_kind = (dv.err == CST_MA) ? DK_SCE_MA : DK_SCE_TA;
                dlv_last = 1'b1;
            end else begin
                dlv_kind = DK_DATA;
                dlv_last = dv_tail && dv.st == SLOT_DONE;
            end
        end else if (dv.err != CST_OK && (!dv.started || dv_empty)) begin
            dlv_kind = DK_TABORT;
            dlv_last = 1'b1;
        end else begin
            dlv_kind = DK_DATA;
            dlv_last = dv_tail && dv.st == SLOT_DONE && dv.err == CST_OK;
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        s_d.rsp_c = RSP_RETRY;
        s_d.rma   = 1'b0;
        s_d.rta   = 1'b0;
        s_d.sta   = 1'b0;

        if (up_valid && up_ready) s_d.slot[launch_idx].st = SLOT_OUT;

        if (cpl_valid && s_q.slot[cpl_idx].st == SLOT_OUT) begin
            if (cpl_st == CST_OK) begin
                if (s_q.slot[cpl_idx].wp < PW'(BEATS)) begin
                    s_d.slot[cpl_idx].data[s_q.slot[cpl_idx].wp[BI-1:0]] = cpl_data;
                    s_d.slot[cpl_idx].wp = PW'(s_q.slot[cpl_idx].wp + PW'(1));
                end
                if (cpl_last) s_d.slot[cpl_idx].st = SLOT_DONE;
            end else begin
                s_d.slot[cpl_idx].err = cpl_st;
                s_d.slot[cpl_idx].st  = SLOT_DONE;
                s_d.rma = cpl_st == CST_MA;
                s_d.rta = cpl_st == CST_TA;
            end
        end

        if (dlv_valid && dlv_ready) begin
            if (dlv_kind != DK_DATA) begin
                s_d.slot[dlv_idx] = '0;
                s_d.sta = (dlv_kind == DK_TABORT) || (dlv_kind == DK_SCE_TA);
            end else if (dlv_last) begin
                s_d.slot[dlv_idx] = '0;
            end else begin
                s_d.slot[dlv_idx].rp      = PW'(dv.rp + PW'(1));
                s_d.slot[dlv_idx].started = 1'b1;
                if (!dv.pcix && dv_tail) s_d.slot[dlv_idx].go = 1'b0;
            end
        end

        if (req_valid) begin
            s_d.rsp_v = 1'b1;
            if (match_hit) begin
                if (has_v[match_idx] && s_d.slot[match_idx].st != SLOT_FREE) begin
                    s_d.slot[match_idx].go = 1'b1;
                    s_d.rsp_c = RSP_CONNECT;
                end
            end else if (free_hit) begin
                s_d.slot[free_idx]      = '0;
                s_d.slot[free_idx].st   = SLOT_WAIT;
                s_d.slot[free_idx].pcix = pcix_mode;
                s_d.slot[free_idx].cmd  = req_cmd;
                s_d.slot[free_idx].addr = req_addr;
                s_d.slot[free_idx].len  = fetch_len;
                s_d.slot[free_idx].rid  = req_rid;
                s_d.slot[free_idx].tag  = req_tag;
                s_d.rsp_c = pcix_mode ? RSP_SPLIT : RSP_QUEUED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rsp_v;
    assign rsp_code  = s_q.rsp_c;
    assign st_rcv_ma = s_q.rma;
    assign st_rcv_ta = s_q.rta;
    assign st_sig_ta = s_q.sta;

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    up_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_v) <= MAX_UP);

    // R11
    rcv_ma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_st == CST_MA && out_v[cpl_idx]) |=> st_rcv_ma);

    // R11
    sig_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready && (dlv_kind == DK_TABORT || dlv_kind == DK_SCE_TA)) |=> st_sig_ta);

    // R10
    sce_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_kind[1]) |-> dlv_last);
endmodule

// File: tb/rd_defer_tracker_test.sv
module rd_defer_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pcix_mode = 1'b0, pf_off_mrd = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_bcnt = '0;
    logic [15:0] req_rid = '0;
    logic [4:0]  req_tag = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic        up_valid, up_ready = 1'b0;
    logic [2:0]  up_idx;
    logic [3:0]  up_cmd;
    logic [31:0] up_addr;
    logic [4:0]  up_len;
    logic        cpl_valid = 1'b0, cpl_last = 1'b0;
    logic [2:0]  cpl_idx = '0;
    logic [31:0] cpl_data = '0;
    logic [1:0]  cpl_st = '0;
    logic        dlv_valid, dlv_ready = 1'b0, dlv_last;
    logic [1:0]  dlv_kind;
    logic [31:0] dlv_data;
    logic [15:0] dlv_rid;
    logic [4:0]  dlv_tag;
    logic        st_rcv_ma, st_rcv_ta, st_sig_ta;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rd_defer_tracker uut (
        .clk(clk), .rst_n(rst_n), .pcix_mode(pcix_mode), .pf_off_mrd(pf_off_mrd),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_bcnt(req_bcnt),
        .req_rid(req_rid), .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .up_valid(up_valid), .up_ready(up_ready), .up_idx(up_idx), .up_cmd(up_cmd),
        .up_addr(up_addr), .up_len(up_len), .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
        .cpl_data(cpl_data), .cpl_last(cpl_last), .cpl_st(cpl_st), .dlv_valid(dlv_valid),
        .dlv_ready(dlv_ready), .dlv_kind(dlv_kind), .dlv_data(dlv_data), .dlv_rid(dlv_rid),
        .dlv_tag(dlv_tag), .dlv_last(dlv_last), .st_rcv_ma(st_rcv_ma), .st_rcv_ta(st_rcv_ta),
        .st_sig_ta(st_sig_ta)
    );

    function automatic logic [4:0] exp_len(input logic px, input logic off,
                                           input logic [3:0] cmd, input logic [4:0] bc);
        if (px || (off && cmd == 4'b0110)) return bc;
        return 5'd16;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic px, input logic [3:0] cmd, input logic [31:0] addr,
                          input logic [4:0] bc, input logic [15:0] rid, input logic [4:0] tag,
                          output logic [1:0] code);
        pcix_mode = px; req_cmd = cmd; req_addr = addr; req_bcnt = bc;
        req_rid = rid; req_tag = tag; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        code = rsp_valid ? rsp_code : 2'bxx;
    endtask

    task automatic take_up(output logic [2:0] idx, output logic [31:0] addr, output logic [4:0] len);
        up_ready = 1'b1;
        while (!up_valid) @(negedge clk);
        idx = up_idx; addr = up_addr; len = up_len;
        @(negedge clk);
        up_ready = 1'b0;
    endtask

    task automatic send_cpl(input logic [2:0] idx, input logic [31:0] d,
                            input logic last, input logic [1:0] st);
        cpl_idx = idx; cpl_data = d; cpl_last = last; cpl_st = st; cpl_valid = 1'b1;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic get_dlv(output logic [1:0] kind, output logic [31:0] d,
                           output logic [15:0] rid, output logic [4:0] tag, output logic last);
        dlv_ready = 1'b1;
        while (!dlv_valid) @(negedge clk);
        kind = dlv_kind; d = dlv_data; rid = dlv_rid; tag = dlv_tag; last = dlv_last;
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0]  code, kind;
        logic [2:0]  idx;
        logic [31:0] a, d;
        logic [4:0]  len, tg;
        logic [15:0] rid;
        logic        last;
        logic [4:0]  blen [8];
        logic [31:0] edata [8][4];
        bit          outst [8];
        int          nl;

        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset rsp", rsp_valid, 0);
        chk("R2 reset up", up_valid, 0);
        chk("R8 reset dlv", dlv_valid, 0);
        chk("R11 reset status", {st_rcv_ma, st_rcv_ta, st_sig_ta}, 0);

        // ---- PCI-X: fill table, cap, random out-of-order completion
        for (int k = 0; k < 8; k++) begin
            blen[k] = 5'(4 * $urandom_range(1, 4));
            do_req(1'b1, 4'hE, 32'h1000 + 32'(k * 64), blen[k], 16'hA00 + 16'(k), 5'(k), code);
            chk("R1 pcix accept", code, 2);
        end
        do_req(1'b1, 4'hE, 32'h9000, 5'd4, 16'hBAD, 5'd31, code);
        chk("R6 full retry", code, 0);
        for (int j = 0; j < 4; j++) begin
            take_up(idx, a, len);
            chk("R2 launch order", idx, j);
            chk("R5 pcix len", len, exp_len(1'b1, pf_off_mrd, 4'hE, blen[j]));
            chk("R2 launch addr", a, 32'h1000 + 32'(j * 64));
            outst[j] = 1;
        end
        chk("R2 cap holds", up_valid, 0);
        nl = 4;
        for (int r = 0; r < 8; r++) begin
            int k;
            int nb;
            do k = $urandom_range(0, 7); while (!outst[k]);
            outst[k] = 0;
            nb = int'(blen[k]) / 4;
            for (int b = 0; b < nb; b++) begin
                edata[k][b] = $urandom;
                send_cpl(3'(k), edata[k][b], b == nb - 1, 2'd0);
            end
            for (int b = 0; b < nb; b++) begin
                get_dlv(kind, d, rid, tg, last);
                chk("R8 kind", kind, 0);
                chk("R8 data order", d, edata[k][b]);
                chk("R8 rid", rid, 16'hA00 + 16'(k));
                chk("R8 tag", tg, k);
                chk("R8 last", last, b == nb - 1);
            end
            if (nl < 8) begin
                take_up(idx, a, len);
                chk("R2 refill order", idx, nl);
                chk("R5 refill len", len, blen[nl]);
                outst[nl] = 1;
                nl++;
            end
        end
        chk("R8 drained", dlv_valid, 0);
        chk("R2 none waiting", up_valid, 0);

        // ---- PCI prefetch lengths and reconnect
        pf_off_mrd = 1'b0;
        do_req(1'b0, 4'b0110, 32'h2000, 5'd4, 16'h11, 5'd1, code);
        chk("R1 pci queued", code, 1);
        take_up(idx, a, len);
        chk("R3 prefetch mrd", len, exp_len(1'b0, 1'b0, 4'b0110, 5'd4));
        pf_off_mrd = 1'b1;
        do_req(1'b0, 4'hC, 32'h2100, 5'd4, 16'h12, 5'd2, code);
        take_up(idx, a, len);
        chk("R4 other cmd prefetches", len, 16);
        do_req(1'b0, 4'b0110, 32'h2200, 5'd8, 16'h13, 5'd3, code);
        take_up(idx, a, len);
        chk("R4 mrd no prefetch", len, 8);
        do_req(1'b0, 4'b0110, 32'h2000, 5'd4, 16'h11, 5'd1, code);
        chk("R7 repeat no data", code, 0);
        send_cpl(3'd0, 32'hD0D0_0001, 1'b0, 2'd0);
        send_cpl(3'd0, 32'hD0D0_0002, 1'b1, 2'd0);
        chk("R7 pci waits connect", dlv_valid, 0);
        do_req(1'b0, 4'b0110, 32'h2000, 5'd4, 16'h11, 5'd1, code);
        chk("R7 connect", code, 3);
        get_dlv(kind, d, rid, tg, last);
        chk("R8 pci beat0", {kind, d, last}, {2'd0, 32'hD0D0_0001, 1'b0});
        get_dlv(kind, d, rid, tg, last);
        chk("R8 pci beat1", {kind, d, last}, {2'd0, 32'hD0D0_0002, 1'b1});
        for (int k = 1; k < 3; k++) begin
            logic [3:0]  c;
            logic [31:0] ad;
            c  = (k == 1) ? 4'hC : 4'b0110;
            ad = (k == 1) ? 32'h2100 : 32'h2200;
            send_cpl(3'(k), 32'hE0 + 32'(k), 1'b1, 2'd0);
            do_req(1'b0, c, ad, 5'd4, 16'h0, 5'd0, code);
            chk("R7 connect other", code, 3);
            get_dlv(kind, d, rid, tg, last);
            chk("R8 pci single", {d, last, tg}, {32'hE0 + 32'(k), 1'b1, 5'(k + 1)});
        end

        // ---- PCI master abort before first connect
        do_req(1'b0, 4'hC, 32'h3000, 5'd4, 16'h21, 5'd4, code);
        take_up(idx, a, len);
        send_cpl(idx, 32'h0, 1'b1, 2'd1);
        chk("R11 rcv ma", {st_rcv_ma, st_rcv_ta}, 2'b10);
        chk("R9 no dlv before connect", dlv_valid, 0);
        do_req(1'b0, 4'hC, 32'h3000, 5'd4, 16'h21, 5'd4, code);
        chk("R7 connect on error", code, 3);
        get_dlv(kind, d, rid, tg, last);
        chk("R9 ta before start", {kind, last}, {2'd1, 1'b1});
        chk("R11 sig ta", st_sig_ta, 1);

        // ---- PCI target abort during stream
        pf_off_mrd = 1'b0;
        do_req(1'b0, 4'b0110, 32'h4000, 5'd4, 16'h31, 5'd5, code);
        take_up(idx, a, len);
        send_cpl(idx, 32'hF001, 1'b0, 2'd0);
        send_cpl(idx, 32'hF002, 1'b0, 2'd0);
        do_req(1'b0, 4'b0110, 32'h4000, 5'd4, 16'h31, 5'd5, code);
        get_dlv(kind, d, rid, tg, last);
        chk("R8 stream beat0", {kind, d, last}, {2'd0, 32'hF001, 1'b0});
        send_cpl(idx, 32'h0, 1'b1, 2'd2);
        chk("R11 rcv ta", {st_rcv_ma, st_rcv_ta}, 2'b01);
        chk("R9 stream not broken", {dlv_valid, dlv_kind, dlv_data}, {1'b1, 2'd0, 32'hF002});
        get_dlv(kind, d, rid, tg, last);
        chk("R9 good data kept", {kind, d, last}, {2'd0, 32'hF002, 1'b0});
        chk("R9 disconnect after drain", dlv_valid, 0);
        do_req(1'b0, 4'b0110, 32'h4000, 5'd4, 16'h31, 5'd5, code);
        chk("R7 reconnect", code, 3);
        get_dlv(kind, d, rid, tg, last);
        chk("R9 ta on reconnect", {kind, last, tg}, {2'd1, 1'b1, 5'd5});

        // ---- PCI-X abort with data pending
        do_req(1'b1, 4'hE, 32'h5000, 5'd8, 16'h41, 5'd6, code);
        take_up(idx, a, len);
        send_cpl(idx, 32'hC001, 1'b0, 2'd0);
        chk("R8 pcix no connect needed", {dlv_valid, dlv_kind}, {1'b1, 2'd0});
        send_cpl(idx, 32'h0, 1'b1, 2'd2);
        chk("R10 data dropped for sce", {dlv_kind, dlv_last}, {2'd3, 1'b1});
        get_dlv(kind, d, rid, tg, last);
        chk("R10 sce ta", {kind, tg}, {2'd3, 5'd6});
        chk("R11 sig ta pcix", st_sig_ta, 1);
        do_req(1'b1, 4'hE, 32'h5100, 5'd4, 16'h42, 5'd7, code);
        take_up(idx, a, len);
        send_cpl(idx, 32'h0, 1'b1, 2'd1);
        get_dlv(kind, d, rid, tg, last);
        chk("R10 sce ma", {kind, last, rid}, {2'd2, 1'b1, 16'h42});
        chk("R11 no sig ta on ma", st_sig_ta, 0);
        chk("R8 all idle", {dlv_valid, up_valid}, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule